// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block sits on the host side of an 8-bit NAND flash bus and runs block erase on its own. A request carries one or two 24-bit row addresses. The block then drives the command latch, address latch, write strobe, read strobe and chip enable lines. It issues either a single-block erase or a dual-plane erase, where two setup-plus-address groups share one confirm. It then follows the ready/busy line of the device, reads the status byte and reports the outcome as a done pulse with a fail flag.

A device reset can also be requested. A reset requested while the block is idle is a standalone operation. A reset requested while an erase is waiting on the device aborts that erase. A programmable limit on the number of busy cycles guards against a device that never becomes ready. Timing on the bus is expressed as whole clock cycles set by parameters.

Top module: `nand_erase_seq`

## Requirements
- R1: A single erase writes the bytes 60h, row byte 0, row byte 1, row byte 2 (least significant first), then D0h. `nandCle` is high for command bytes and `nandAle` is high for address bytes, and the two are never high together.
- R2: A dual erase (`reqDual`=1) writes 60h, the three bytes of row A, 60h, the three bytes of row B, then one D0h, with no wait between the two groups.
- R3: With the default PAGE_BITS=6, row bits [5:0] are sent as 0. Row bit 6 (the plane bit) is sent as 0 for row A and as 1 for row B. All other row bits are sent unchanged.
- R4: For every written byte, `nandWeN` is low for exactly PULSE_CYC clock cycles and then high for PULSE_CYC cycles. `nandIoOut` is stable when `nandWeN` rises, and `nandCeN` is low whenever either strobe is low.
- R5: After D0h the block waits SETTLE_CYC cycles and then waits for `nandRdy` to be high. It then writes 70h and reads one status byte, with `nandReN` low for PULSE_CYC cycles. It never drives `nandIoOe` while `nandReN` is low.
- R6: If status bit 6 (ready) is 0, the block writes 70h again and rereads, repeating until bit 6 is 1.
- R7: `done` is a one-cycle pulse. With it, `fail` equals status bit 0, and `fail` holds until the next accepted request.
- R8: If `nandRdy` stays low for more than `maxEraseCycles` cycles of the wait, the block ends with `done`, `fail`=1 and `timeout`=1, and no status read.
- R9: `reqReset` while idle writes FFh, waits for `nandRdy` high, and ends with `done` and `fail`=0, without a status read.
- R10: `reqReset` while an erase waits on `nandRdy` writes FFh at once, waits for `nandRdy` high, and ends with `done` and `fail`=1.
- R11: `busy` is high from the cycle after acceptance until `done`. Erase requests while busy are ignored. If `reqReset` and `reqValid` arrive together while idle, only the reset runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Erase request, taken when idle |
| reqDual | input | 1 | 1 selects dual-plane erase |
| reqReset | input | 1 | Device reset request |
| rowAddrA | input | 24 | First block row address |
| rowAddrB | input | 24 | Second block row address (dual only) |
| maxEraseCycles | input | TIMER_W | Busy-wait limit in cycles |
| nandIoOut | output | 8 | Byte driven onto the I/O bus |
| nandIoOe | output | 1 | Output enable for the I/O bus |
| nandIoIn | input | 8 | Byte read from the I/O bus |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandCeN | output | 1 | Chip enable, active low |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandRdy | input | 1 | Device ready (1) / busy (0) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last operation |
| timeout | output | 1 | Last operation hit the busy limit |

## Verification
The assertions check the bus rules on every cycle:
- the latch enables are never high together;
- the data is steady at each write strobe rising edge;
- chip enable is low under every strobe;
- the block never drives the bus during a read;
- `done` is a single-cycle pulse, and a timeout always comes with a failure.

The byte order, the masking of the page and plane bits, the repeated status polls, the timeout, the abort by reset and the ignoring of requests while busy depend on what the device model does. Only the bench scenarios can show them, by comparing the logged bus bytes and the results with values computed from the row addresses.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  localparam int ROW_W = 24;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_RESET       = 8'hFF;
  localparam int STAT_READY_BIT = 6;
  localparam int STAT_FAIL_BIT  = 0;

  typedef enum logic [3:0] {
    STEP_SETUP_A = 4'd0,
    STEP_A0      = 4'd1,
    STEP_A1      = 4'd2,
    STEP_A2      = 4'd3,
    STEP_SETUP_B = 4'd4,
    STEP_B0      = 4'd5,
    STEP_B1      = 4'd6,
    STEP_B2      = 4'd7,
    STEP_CONFIRM = 4'd8,
    STEP_STATUS  = 4'd9,
    STEP_RESET   = 4'd10
  } busStep_e;

  typedef struct packed {
    logic     capture;
    busStep_e step;
    logic     drive;
    logic     latchStat;
  } dpCtrl_t;
endpackage

// File: rtl/nand_erase_dp.sv
module nand_erase_dp
  import nand_erase_pkg::*;
#(
  parameter int PAGE_BITS = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [ROW_W-1:0] rowA,
  input  logic [ROW_W-1:0] rowB,
  input  logic [7:0]       ioIn,
  output logic [7:0]       ioOut,
  output logic             ioOe,
  output logic             statReady,
  output logic             statFail
);
  localparam logic [ROW_W-1:0] PAGE_MASK = ROW_W'((1 << PAGE_BITS) - 1);
  localparam logic [ROW_W-1:0] PLANE_BIT = ROW_W'(1) << PAGE_BITS;
  localparam logic [ROW_W-1:0] KEEP_MASK = ~(PAGE_MASK | PLANE_BIT);

  logic [ROW_W-1:0] rowAReg, rowBReg;
  logic [7:0]       statReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowAReg <= '0;
      rowBReg <= '0;
      statReg <= '0;
    end else begin
      if (ctl.capture) begin
        rowAReg <= rowA & KEEP_MASK;
        rowBReg <= (rowB & KEEP_MASK) | PLANE_BIT;
      end
      if (ctl.latchStat) statReg <= ioIn;
    end
  end

  always_comb begin
    unique case (ctl.step)
      STEP_SETUP_A, STEP_SETUP_B: ioOut = CMD_ERASE_SETUP;
      STEP_A0:      ioOut = rowAReg[7:0];
      STEP_A1:      ioOut = rowAReg[15:8];
      STEP_A2:      ioOut = rowAReg[23:16];
      STEP_B0:      ioOut = rowBReg[7:0];
      STEP_B1:      ioOut = rowBReg[15:8];
      STEP_B2:      ioOut = rowBReg[23:16];
      STEP_CONFIRM: ioOut = CMD_ERASE_GO;
      STEP_STATUS:  ioOut = CMD_STATUS;
      STEP_RESET:   ioOut = CMD_RESET;
      default:      ioOut = 8'h00;
    endcase
  end

  assign ioOe      = ctl.drive;
  assign statReady = statReg[STAT_READY_BIT];
  assign statFail  = statReg[STAT_FAIL_BIT];

  // R5: no status latch while the bus is driven
  p_latch_not_driving_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchStat |-> !ctl.drive);
endmodule

// File: rtl/nand_erase_ctrl.sv
module nand_erase_ctrl
  import nand_erase_pkg::*;
#(
  parameter int PULSE_CYC  = 2,
  parameter int SETTLE_CYC = 3,
  parameter int TIMER_W    = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqDual,
  input  logic               reqReset,
  input  logic [TIMER_W-1:0] maxCycles,
  input  logic               rdy,
  input  logic               statReady,
  input  logic               statFail,
  output dpCtrl_t            ctl,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic               ceN,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic               timeout
);
  localparam int PH_W = $clog2(2 * PULSE_CYC);
  localparam int ST_W = $clog2(SETTLE_CYC + 1);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(2 * PULSE_CYC - 1);
  localparam logic [PH_W-1:0] PH_PULSE = PH_W'(PULSE_CYC);
  localparam logic [ST_W-1:0] ST_LAST  = ST_W'(SETTLE_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_SETTLE, S_WAIT, S_READ, S_EVAL} state_e;

  state_e             state;
  busStep_e           step;
  logic [PH_W-1:0]    ph;
  logic [ST_W-1:0]    settleCnt;
  logic [TIMER_W-1:0] waitCnt;
  logic               isDual, isReset, aborted;
  logic               isCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      step      <= STEP_SETUP_A;
      ph        <= '0;
      settleCnt <= '0;
      waitCnt   <= '0;
      isDual    <= 1'b0;
      isReset   <= 1'b0;
      aborted   <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          ph <= '0;
          if (reqReset) begin
            step    <= STEP_RESET;
            isReset <= 1'b1;
            aborted <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
            state   <= S_WRITE;
          end else if (reqValid) begin
            step    <= STEP_SETUP_A;
            isDual  <= reqDual;
            isReset <= 1'b0;
            aborted <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
            state   <= S_WRITE;
          end
        end
        S_WRITE: begin
          ph <= ph + 1'b1;
          if (ph == PH_LAST) begin
            ph <= '0;
            if (step == STEP_CONFIRM || step == STEP_RESET) begin
              settleCnt <= '0;
              state     <= S_SETTLE;
            end else if (step == STEP_STATUS) begin
              state <= S_READ;
            end else if (step == STEP_A2 && !isDual) begin
              step <= STEP_CONFIRM;
            end else begin
              step <= busStep_e'(step + 4'd1);
            end
          end
        end
        S_SETTLE: begin
          settleCnt <= settleCnt + 1'b1;
          if (settleCnt == ST_LAST) begin
            waitCnt <= '0;
            state   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!isReset && reqReset) begin
            step    <= STEP_RESET;
            isReset <= 1'b1;
            aborted <= 1'b1;
            ph      <= '0;
            state   <= S_WRITE;
          end else if (rdy) begin
            if (isReset) begin
              done  <= 1'b1;
              fail  <= aborted;
              state <= S_IDLE;
            end else begin
              step  <= STEP_STATUS;
              ph    <= '0;
              state <= S_WRITE;
            end
          end else if (waitCnt == maxCycles) begin
            done    <= 1'b1;
            fail    <= 1'b1;
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_READ: begin
          ph <= ph + 1'b1;
          if (ph == PH_LAST) begin
            ph    <= '0;
            state <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (statReady) begin
            done  <= 1'b1;
            fail  <= statFail;
            state <= S_IDLE;
          end else begin
            step  <= STEP_STATUS;
            state <= S_WRITE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    isCmd = (step == STEP_SETUP_A) || (step == STEP_SETUP_B) ||
            (step == STEP_CONFIRM) || (step == STEP_STATUS) || (step == STEP_RESET);
    busy          = (state != S_IDLE);
    ceN           = !busy;
    cle           = (state == S_WRITE) && isCmd;
    ale           = (state == S_WRITE) && !isCmd;
    weN           = !((state == S_WRITE) && (ph < PH_PULSE));
    reN           = !((state == S_READ) && (ph < PH_PULSE));
    ctl.capture   = (state == S_IDLE) && !reqReset && reqValid;
    ctl.step      = step;
    ctl.drive     = (state == S_WRITE);
    ctl.latchStat = (state == S_READ) && (ph == PH_PULSE - 1'b1);
  end

  p_cle_ale_excl_r1: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  p_ce_under_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!weN || !reN) |-> !ceN);
  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> (weN && !ctl.drive));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  p_timeout_fails_r8: assert property (@(posedge clk) disable iff (!rstN) timeout |-> fail);
  p_idle_at_done_r11: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int PULSE_CYC  = 2,
  parameter int SETTLE_CYC = 3,
  parameter int PAGE_BITS  = 6,
  parameter int TIMER_W    = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqDual,
  input  logic               reqReset,
  input  logic [23:0]        rowAddrA,
  input  logic [23:0]        rowAddrB,
  input  logic [TIMER_W-1:0] maxEraseCycles,
  output logic [7:0]         nandIoOut,
  output logic               nandIoOe,
  input  logic [7:0]         nandIoIn,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandCeN,
  output logic               nandWeN,
  output logic               nandReN,
  input  logic               nandRdy,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic               timeout
);
  dpCtrl_t ctl;
  logic    statReady, statFail;

  nand_erase_ctrl #(
    .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC), .TIMER_W(TIMER_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDual(reqDual),
    .reqReset(reqReset), .maxCycles(maxEraseCycles), .rdy(nandRdy),
    .statReady(statReady), .statFail(statFail), .ctl(ctl),
    .cle(nandCle), .ale(nandAle), .weN(nandWeN), .reN(nandReN), .ceN(nandCeN),
    .busy(busy), .done(done), .fail(fail), .timeout(timeout)
  );

  nand_erase_dp #(.PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rowA(rowAddrA), .rowB(rowAddrB),
    .ioIn(nandIoIn), .ioOut(nandIoOut), .ioOe(nandIoOe),
    .statReady(statReady), .statFail(statFail)
  );

  p_io_stable_at_latch_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> $stable(nandIoOut));
endmodule

// File: tb/nand_erase_seq_bench.sv
module nand_erase_seq_bench;
  localparam int PULSE = 2;
  localparam int TW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqDual = 1'b0, reqReset = 1'b0;
  logic [23:0] rowA = '0, rowB = '0;
  logic [TW-1:0] maxCyc = TW'(1000);
  logic [7:0] ioOut, ioIn;
  logic ioOe, cle, ale, ceN, weN, reN, busy, done, fail, timeout;
  logic rdy = 1'b1;

  always #4 clk = ~clk;

  nand_erase_seq u_nand_erase_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDual(reqDual), .reqReset(reqReset),
    .rowAddrA(rowA), .rowAddrB(rowB), .maxEraseCycles(maxCyc),
    .nandIoOut(ioOut), .nandIoOe(ioOe), .nandIoIn(ioIn), .nandCle(cle), .nandAle(ale),
    .nandCeN(ceN), .nandWeN(weN), .nandReN(reN), .nandRdy(rdy),
    .busy(busy), .done(done), .fail(fail), .timeout(timeout)
  );

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] logB[16];
  logic       logC[16];
  int logN = 0, busyLen = 10, busyLeft = 0, notReadyLeft = 0, weLow = 0;
  bit failBit = 0, prevWe = 1, prevRe = 1;

  assign ioIn = !reN ? ((notReadyLeft > 0) ? 8'h00 : (8'hE0 | {7'd0, failBit})) : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      if (!weN) weLow++;
      if (!prevWe && weN) begin
        check(weLow == PULSE && !ceN && ioOe, "R4 strobe width", weLow, PULSE);
        if (logN < 16) begin
          logB[logN] = ioOut;
          logC[logN] = cle;
        end
        check(cle != ale, "R1 latch enables", {cle, ale}, 2'b01);
        logN++;
        weLow = 0;
        if (cle && (ioOut == 8'hD0 || ioOut == 8'hFF)) begin
          rdy = 1'b0;
          busyLeft = busyLen;
        end
      end else if (!rdy) begin
        if (busyLeft > 0) busyLeft--;
        else rdy = 1'b1;
      end
      if (!prevRe && reN && notReadyLeft > 0) notReadyLeft--;
      prevWe = weN;
      prevRe = reN;
    end
  end

  logic [7:0] expB[16];
  logic       expC[16];
  int expN;
  task automatic push(input logic [7:0] b, input logic c);
    expB[expN] = b;
    expC[expN] = c;
    expN++;
  endtask

  task automatic compareLog(input string req);
    check(logN == expN, {req, " byte count"}, logN, expN);
    for (int k = 0; k < expN && k < logN; k++) begin
      check(logB[k] == expB[k] && logC[k] == expC[k], req, {logC[k], logB[k]}, {expC[k], expB[k]});
    end
  endtask

  task automatic waitRdy();
    while (!rdy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done, {req, " done seen"}, done, 1);
  endtask

  task automatic runErase(input bit dual, input logic [23:0] ra, input logic [23:0] rb,
                          input int blen, input bit fb, input int polls, input bit expTo);
    logic [23:0] ma, mb;
    waitRdy();
    busyLen = blen;
    failBit = fb;
    notReadyLeft = polls;
    logN = 0;
    reqValid = 1'b1; reqDual = dual; rowA = ra; rowB = rb;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy, "R11 busy after accept", busy, 1);
    waitDone("R7");
    check(fail == (fb || expTo), "R7 fail bit", fail, fb || expTo);
    check(timeout == expTo, "R8 timeout flag", timeout, expTo);
    ma = {ra[23:7], 7'd0};
    mb = {rb[23:7], 1'b1, 6'd0};
    expN = 0;
    push(8'h60, 1); push(ma[7:0], 0); push(ma[15:8], 0); push(ma[23:16], 0);
    if (dual) begin
      push(8'h60, 1); push(mb[7:0], 0); push(mb[15:8], 0); push(mb[23:16], 0);
    end
    push(8'hD0, 1);
    if (!expTo) for (int p = 0; p <= polls; p++) push(8'h70, 1);
    compareLog(dual ? "R2 R3 R6 dual sequence" : "R1 R3 R5 single sequence");
    @(negedge clk);
    check(!done && !busy, "R7 done is one pulse", {done, busy}, 0);
    check(fail == (fb || expTo), "R7 fail held", fail, fb || expTo);
  endtask

  initial begin
    logic [23:0] rows[6];
    rows[0] = 24'h000000; rows[1] = 24'hFFFFFF; rows[2] = 24'hA5C37F;
    rows[3] = 24'h123456; rows[4] = 24'h7F8040; rows[5] = 24'h0100BF;
    repeat (3) @(negedge clk);
    check(!busy && !done && weN && reN && ceN && !cle && !ale, "R11 reset state",
          {busy, done, weN, reN, ceN}, 5'b00111);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++)
      for (int d = 0; d < 2; d++)
        runErase(d[0], rows[i], rows[5-i] ^ 24'h5A5A5A, 5 + 3 * i, (i + d) % 2 == 1, (i + d) % 3, 0);

    // R8: busy longer than the limit
    maxCyc = TW'(60);
    runErase(1'b0, 24'h3C3C3C, 24'h0, 300, 0, 0, 1);
    maxCyc = TW'(1000);

    // R9 and R11 priority: reset and erase requested together while idle
    waitRdy();
    busyLen = 12; logN = 0;
    reqReset = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    reqReset = 1'b0; reqValid = 1'b0;
    waitDone("R9");
    check(!fail && !timeout, "R9 reset result", {fail, timeout}, 0);
    expN = 0; push(8'hFF, 1);
    compareLog("R9 R11 reset only");

    // R11: erase request while busy is ignored
    waitRdy();
    busyLen = 30; failBit = 0; notReadyLeft = 0; logN = 0;
    reqValid = 1'b1; reqDual = 1'b0; rowA = 24'h00ABCD;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (10) @(negedge clk);
    reqValid = 1'b1; reqDual = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone("R11");
    repeat (40) @(negedge clk);
    check(logN == 6 && !busy, "R11 request during busy ignored", logN, 6);

    // R10: reset aborts a running erase
    waitRdy();
    busyLen = 400; failBit = 0; logN = 0;
    reqValid = 1'b1; reqDual = 1'b0; rowA = 24'h111111;
    @(negedge clk);
    reqValid = 1'b0;
    while (logN < 5) @(negedge clk);
    repeat (20) @(negedge clk);
    busyLen = 10;
    reqReset = 1'b1;
    @(negedge clk);
    reqReset = 1'b0;
    waitDone("R10");
    check(fail && !timeout, "R10 abort reports fail", {fail, timeout}, 2'b10);
    expN = 0;
    push(8'h60, 1); push(8'h00, 0); push(8'h11, 0); push(8'h11, 0); push(8'hD0, 1); push(8'hFF, 1);
    compareLog("R10 abort sequence");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule